// File: doc/BRIEF.md
# Chained-Half Down-Counting Interval Timer

This block is a 32-bit interval timer. Two 16-bit counter halves are chained into one down-counter, so the upper half borrows from the lower. Software drives it through a plain strobe interface (write enable, read enable, word address, data). Through that interface it sets a start value, picks one-shot or periodic operation, starts and stops the count, and handles a sticky timeout flag with a mask and a write-one-to-clear register.

Each time the count passes through zero, the timer reloads the start value, raises the timeout flag and emits a one-cycle trigger. In one-shot operation it then drops its own run bit. A debug-halt input can freeze the count, but only when software has armed the stall option. Writing a new start value while the timer runs takes hold on the very next clock.

Register map (word addresses): 0 control (bits 1:0 mode, bit 2 run, bit 3 stall-enable), 1 start value, 2 current count (read only), 3 mask (bit 0), 4 raw flag (bit 0, read only), 5 masked flag (bit 0, read only), 6 clear (bit 0, write one to clear). When read enable is low, or the address is unmapped, the read data is zero.

Top module: `cascade_timer`

## Requirements
- R1: A write to address 1 loads bits 31:16 into the upper half and bits 15:0 into the lower half, and sets the count to that value at the same edge. A read of address 2 returns the upper half in bits 31:16 and the lower half in bits 15:0. A decrement borrows from the upper half when the lower half is zero, so 0x00020000 is followed by 0x0001FFFF.
- R2: Once the run bit (address 0, bit 2) is set with a valid mode, the count falls by one on every clock, starting from the value it held when run was set.
- R3: When the running count is 0, the next edge reloads the start value. With start value L, a timeout therefore occurs every L+1 cycles.
- R4: Mode 01 (one-shot) clears the run bit at the timeout and stops counting at the reloaded value. Mode 10 (periodic) keeps counting after the reload.
- R5: A timeout sets the raw flag (address 4, bit 0). The flag stays set until a write to address 6 with bit 0 equal to 1. A write there with bit 0 equal to 0 has no effect.
- R6: The masked flag (address 5) and the output irq both equal the raw flag AND the mask bit (address 3, bit 0).
- R7: A start-value write while the timer runs makes the count equal the new value after that edge. Counting then continues down from it.
- R8: While the stall-enable bit (address 0, bit 3) is 1 and dbgHalt is high, the count holds its value. With stall-enable at 0, dbgHalt has no effect.
- R9: Mode values 00 and 11 leave the count unchanged even with the run bit set.
- R10: toPulse is high for exactly the cycle in which the raw flag is first set by a timeout, and low on the next cycle unless another timeout occurs.
- R11: When a clear write and a timeout fall in the same cycle, the raw flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data (combinational, zero when rdEn is low) |
| dbgHalt | input | 1 | Debug-halt request |
| irq | output | 1 | Masked timeout interrupt |
| toPulse | output | 1 | One-cycle timeout trigger |

## Verification
Two pairs of functions can fall in the same cycle. The first is a clear write against a new timeout: the bench loads a start value of 0 in periodic mode, so a timeout occurs on every clock, then writes the clear bit and expects the raw flag still read back as 1. The second is a start-value write against a running decrement: the bench rewrites the start value mid-count and expects the count to read exactly the new value one clock later and one less a clock after that.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE_A   = 2'b00,
    MODE_ONESHOT  = 2'b01,
    MODE_PERIODIC = 2'b10,
    MODE_IDLE_B   = 2'b11
  } tmode_e;

  // strobes from control to the counter datapath
  typedef struct packed {
    logic loadWr;
    logic decr;
    logic reload;
    logic freeze;
  } cnt_strb_t;

  localparam int unsigned ADR_CTRL  = 0;
  localparam int unsigned ADR_LOAD  = 1;
  localparam int unsigned ADR_COUNT = 2;
  localparam int unsigned ADR_MASK  = 3;
  localparam int unsigned ADR_RAW   = 4;
  localparam int unsigned ADR_MSTAT = 5;
  localparam int unsigned ADR_CLEAR = 6;

endpackage

// File: rtl/ctmr_dpath.sv
module ctmr_dpath
  import ctmr_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int NHALF  = 2,
  localparam int DATA_W = HALF_W * NHALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cnt_strb_t         strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] cntVec,
  output logic              cntZero
);

  logic [DATA_W-1:0] loadVec;
  logic [NHALF-1:0]  borrow;

  assign borrow[0] = 1'b1;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    logic [HALF_W-1:0] halfCnt;
    logic [HALF_W-1:0] halfLoad;

    if (h > 0) begin : g_chain
      assign borrow[h] = borrow[h-1] & ~|cntVec[(h-1)*HALF_W +: HALF_W];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        halfCnt  <= '0;
        halfLoad <= '0;
      end else if (strb.loadWr) begin
        halfLoad <= wrData[h*HALF_W +: HALF_W];
        halfCnt  <= wrData[h*HALF_W +: HALF_W];
      end else if (strb.reload) begin
        halfCnt  <= halfLoad;
      end else if (strb.decr && borrow[h]) begin
        halfCnt  <= halfCnt - 1'b1;
      end
    end

    assign cntVec[h*HALF_W +: HALF_W]  = halfCnt;
    assign loadVec[h*HALF_W +: HALF_W] = halfLoad;
  end

  assign cntZero = (cntVec == '0);

  AST_DECR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.decr && !strb.loadWr) |=> cntVec == $past(cntVec) - 1'b1); // R2

  AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.reload && !strb.loadWr) |=> cntVec == $past(loadVec)); // R3

  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadWr |=> cntVec == $past(wrData)); // R7

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.freeze && !strb.loadWr) |=> $stable(cntVec)); // R8

endmodule

// File: rtl/ctmr_ctrl.sv
module ctmr_ctrl
  import ctmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        cfgBits,
  input  logic              dbgHalt,
  input  logic [DATA_W-1:0] cntVal,
  input  logic              cntZero,
  output cnt_strb_t         strb,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              toPulse
);

  tmode_e modeQ;
  logic   runQ, stallQ, maskQ, rawQ, pulseQ;
  logic   cfgWr, ldWr, maskWr, clrHit;
  logic   modeOk, frozen, active, toEvent;

  assign cfgWr  = wrEn && (addr == ADDR_W'(ADR_CTRL));
  assign ldWr   = wrEn && (addr == ADDR_W'(ADR_LOAD));
  assign maskWr = wrEn && (addr == ADDR_W'(ADR_MASK));
  assign clrHit = wrEn && (addr == ADDR_W'(ADR_CLEAR)) && cfgBits[0];

  assign modeOk  = (modeQ == MODE_ONESHOT) || (modeQ == MODE_PERIODIC);
  assign frozen  = stallQ && dbgHalt;
  assign active  = runQ && modeOk && !frozen;
  assign toEvent = active && cntZero;

  always_comb begin
    strb.loadWr = ldWr;
    strb.reload = toEvent;
    strb.decr   = active && !cntZero;
    strb.freeze = runQ && modeOk && frozen;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ  <= MODE_IDLE_A;
      runQ   <= 1'b0;
      stallQ <= 1'b0;
      maskQ  <= 1'b0;
      rawQ   <= 1'b0;
      pulseQ <= 1'b0;
    end else begin
      if (cfgWr) begin
        modeQ  <= tmode_e'(cfgBits[1:0]);
        runQ   <= cfgBits[2];
        stallQ <= cfgBits[3];
      end else if (toEvent && modeQ == MODE_ONESHOT) begin
        runQ   <= 1'b0;
      end
      if (maskWr) maskQ <= cfgBits[0];
      rawQ   <= toEvent || (rawQ && !clrHit);
      pulseQ <= toEvent;
    end
  end

  assign irq     = rawQ && maskQ;
  assign toPulse = pulseQ;

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (addr == ADDR_W'(ADR_CTRL))       rdData = DATA_W'({stallQ, runQ, modeQ});
      else if (addr == ADDR_W'(ADR_COUNT)) rdData = cntVal;
      else if (addr == ADDR_W'(ADR_MASK))  rdData = DATA_W'(maskQ);
      else if (addr == ADDR_W'(ADR_RAW))   rdData = DATA_W'(rawQ);
      else if (addr == ADDR_W'(ADR_MSTAT)) rdData = DATA_W'(rawQ && maskQ);
    end
  end

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cntZero && active && modeQ == MODE_ONESHOT && !cfgWr) |=> !runQ); // R4

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rawQ && !clrHit) |=> rawQ); // R5

  AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (clrHit && strb.reload) |=> rawQ); // R11

  AST_PULSE_WITH_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    toPulse |-> rawQ); // R10

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !modeOk |-> !(strb.decr || strb.reload)); // R9

endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import ctmr_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int NHALF  = 2,
  parameter int ADDR_W = 3,
  localparam int DATA_W = HALF_W * NHALF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              dbgHalt,
  output logic              irq,
  output logic              toPulse
);

  cnt_strb_t         strb;
  logic [DATA_W-1:0] cntVec;
  logic              cntZero;

  ctmr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .cfgBits(wrData[3:0]), .dbgHalt(dbgHalt), .cntVal(cntVec),
    .cntZero(cntZero), .strb(strb), .rdData(rdData), .irq(irq),
    .toPulse(toPulse)
  );

  ctmr_dpath #(.HALF_W(HALF_W), .NHALF(NHALF)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrData(wrData),
    .cntVec(cntVec), .cntZero(cntZero)
  );

endmodule

// File: tb/sim_cascade_timer.sv
module sim_cascade_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_LOAD = 3'd1, A_COUNT = 3'd2,
                         A_MASK = 3'd3, A_RAW = 3'd4, A_MSTAT = 3'd5, A_CLEAR = 3'd6;
  // {mode[1:0], start value[31:0]}
  localparam logic [33:0] VEC [0:3] = '{
    {2'b01, 32'd3}, {2'b10, 32'd0}, {2'b10, 32'd7}, {2'b01, 32'd5}
  };

  logic clk = 1'b0;
  logic rst_n, wrEn, rdEn, dbgHalt;
  logic [2:0]  addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic irq, toPulse;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_timer u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .dbgHalt(dbgHalt), .irq(irq),
    .toPulse(toPulse)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rdEn = 1'b1; addr = a;
    #1;
    v = rdData;
    rdEn = 1'b0;
  endtask

  task automatic waitPulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!toPulse && n < 2000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, v0;
    int n;
    rst_n = 1'b0; wrEn = 1'b0; rdEn = 1'b0; dbgHalt = 1'b0;
    addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(A_COUNT, v); chk("reset count", v, 32'd0);
    rd(A_CTRL, v);  chk("reset ctrl", v, 32'd0);
    rd(A_RAW, v);   chk("reset raw", v, 32'd0);
    chk("reset irq", {31'd0, irq}, 32'd0);
    chk("reset toPulse", {31'd0, toPulse}, 32'd0);

    // table walk: period, one-shot stop vs periodic continue
    for (int i = 0; i < 4; i++) begin
      logic [31:0] ld;
      logic [1:0]  md;
      {md, ld} = VEC[i];
      wr(A_CTRL, 32'd0);
      wr(A_CLEAR, 32'd1);
      wr(A_LOAD, ld);
      wr(A_CTRL, {29'd0, 1'b1, md});
      waitPulse(n);
      chk("R3 period to first timeout", n, ld + 1);
      rd(A_RAW, v); chk("R5 raw set at timeout", v, 32'd1);
      rd(A_COUNT, v); chk("R3 reload value", v, ld);
      if (md == 2'b01) begin
        rd(A_CTRL, v); chk("R4 one-shot clears run", v[2], 1'b0);
        @(negedge clk);
        chk("R10 pulse lasts one cycle", {31'd0, toPulse}, 32'd0);
        repeat (3) @(negedge clk);
        rd(A_COUNT, v); chk("R4 one-shot holds", v, ld);
      end else begin
        rd(A_CTRL, v); chk("R4 periodic keeps run", v[2], 1'b1);
        waitPulse(n);
        chk("R4 periodic second timeout", n, ld + 1);
      end
    end

    // R1 halves ordering and borrow
    wr(A_CTRL, 32'd0);
    wr(A_LOAD, 32'h0002_0000);
    rd(A_COUNT, v); chk("R1 halves joined", v, 32'h0002_0000);
    wr(A_CTRL, 32'h6);
    rd(A_COUNT, v); chk("R2 starts from loaded value", v, 32'h0002_0000);
    @(negedge clk);
    rd(A_COUNT, v); chk("R1 borrow across halves", v, 32'h0001_FFFF);
    @(negedge clk);
    rd(A_COUNT, v); chk("R2 one per cycle", v, 32'h0001_FFFE);

    // R9 idle modes
    wr(A_CTRL, 32'd0);
    wr(A_CLEAR, 32'd1);
    wr(A_LOAD, 32'd5);
    wr(A_CTRL, 32'h4);
    repeat (8) @(negedge clk);
    rd(A_COUNT, v); chk("R9 mode 00 idle", v, 32'd5);
    wr(A_CTRL, 32'h7);
    repeat (8) @(negedge clk);
    rd(A_COUNT, v); chk("R9 mode 11 idle", v, 32'd5);
    rd(A_RAW, v); chk("R9 no timeout when idle", v, 32'd0);

    // R7 reload while running
    wr(A_CTRL, 32'd0);
    wr(A_LOAD, 32'd1000);
    wr(A_CTRL, 32'h6);
    repeat (3) @(negedge clk);
    rd(A_COUNT, v); chk("R2 running count", v, 32'd997);
    wr(A_LOAD, 32'd50);
    rd(A_COUNT, v); chk("R7 new value next clock", v, 32'd50);
    @(negedge clk);
    rd(A_COUNT, v); chk("R7 continues from new value", v, 32'd49);

    // R8 stall
    wr(A_LOAD, 32'd200);
    wr(A_CTRL, 32'hE);
    rd(A_COUNT, v0);
    dbgHalt = 1'b1;
    repeat (5) @(negedge clk);
    rd(A_COUNT, v); chk("R8 frozen during halt", v, v0);
    dbgHalt = 1'b0;
    @(negedge clk);
    rd(A_COUNT, v); chk("R8 resumes after halt", v, v0 - 1);
    wr(A_CTRL, 32'h6);
    rd(A_COUNT, v0);
    dbgHalt = 1'b1;
    @(negedge clk);
    rd(A_COUNT, v); chk("R8 halt ignored without stall", v, v0 - 1);
    dbgHalt = 1'b0;

    // R5 / R6 mask and clear
    wr(A_CTRL, 32'd0);
    wr(A_CLEAR, 32'd1);
    wr(A_MASK, 32'd0);
    wr(A_LOAD, 32'd2);
    wr(A_CTRL, 32'h5);
    waitPulse(n);
    rd(A_RAW, v); chk("R5 raw after one-shot", v, 32'd1);
    chk("R6 irq masked off", {31'd0, irq}, 32'd0);
    rd(A_MSTAT, v); chk("R6 masked status off", v, 32'd0);
    wr(A_MASK, 32'd1);
    chk("R6 irq unmasked", {31'd0, irq}, 32'd1);
    rd(A_MSTAT, v); chk("R6 masked status on", v, 32'd1);
    wr(A_CLEAR, 32'd0);
    rd(A_RAW, v); chk("R5 clear with bit0=0 ignored", v, 32'd1);
    wr(A_CLEAR, 32'd1);
    rd(A_RAW, v); chk("R5 clear removes flag", v, 32'd0);
    chk("R6 irq drops", {31'd0, irq}, 32'd0);

    // R11 clear against simultaneous timeout
    wr(A_LOAD, 32'd0);
    wr(A_CTRL, 32'h6);
    repeat (2) @(negedge clk);
    wr(A_CLEAR, 32'd1);
    rd(A_RAW, v); chk("R11 timeout wins over clear", v, 32'd1);
    chk("R10 pulse with timeout", {31'd0, toPulse}, 32'd1);
    wr(A_CTRL, 32'd0);

    summary();
    $finish;
  end
endmodule